// File: doc/BRIEF.md
# Serial Converter Frame Sequencer

This block paces a successive-approximation style converter through fixed frames of sixteen clocks. An external comparator, or a test stimulus, supplies the result one bit at a time on `ser_in`. The sequencer decides on which falling edges that bit is taken and presented on `ser_out`. It gathers the bits into a byte and publishes the byte on `result` at a fixed clock of the frame. That byte stays on `result` until the next frame replaces it.

While `pwr_down` is high the block is idle. Once it goes low, frames run back to back. Each frame flags the arrival of a new byte with a one-clock strobe, `result_valid`. The frame closes with a one-clock interrupt, `frame_irq`. Raising `pwr_down` stops the sequence at once, in any clock of the frame. The published byte survives the power-down.

Clocks of a frame are numbered 1 to 16 by the rising edge that opens them. The falling edge of clock n falls between rising edges n and n+1. After `pwr_down` is released, the next rising edge is the start of clock 1. The first falling edge of a frame is the one inside the interval where `pwr_down` has just been released, or the interval that follows rising edge 16 of the previous frame.

Top module: `sadc_frame_seq`

## Requirements
- R1: While `pwr_down` is high, `frame_irq`, `result_valid` and `ser_out` stay low, and no frame advances.
- R2: Frames are 16 clocks long and repeat with no gap while `pwr_down` stays low. The rising edge that ends one frame begins the next.
- R3: The first five falling edges of a frame belong to the conversion phase, and `ser_out` is driven low on them. The conversion phase ends on the sixth falling edge.
- R4: On falling edges 6 through 13 of a frame, `ser_out` takes the value of `ser_in` at that edge. These eight bits arrive most significant bit first. On every other falling edge, `ser_out` is driven low.
- R5: The 13th rising edge of the frame loads `result`. The first serial bit goes to `result[7]` and the last to `result[0]`.
- R6: `result` changes at no other time. It keeps its value through a power-down and across the following restart.
- R7: `result_valid` is high for exactly one clock, from the 13th to the 14th rising edge of every frame.
- R8: `frame_irq` is high for exactly one clock, from the 15th to the 16th rising edge of every frame. The interrupt is never high in two consecutive clocks.
- R9: Raising `pwr_down` clears `frame_irq`, `result_valid` and `ser_out` at once, without waiting for a clock edge. Partly received bits are dropped. After release, the sequence starts again at clock 1 of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| pwr_down | input | 1 | High holds the block idle; rising edge resets it asynchronously |
| ser_in | input | 1 | Serial result bit from the comparator |
| ser_out | output | 1 | Serial bit presented on the falling edge |
| result | output | 8 | Parallel result, held between updates |
| result_valid | output | 1 | One-clock strobe in the clock that follows a `result` update |
| frame_irq | output | 1 | One-clock end-of-frame interrupt |

## Verification
The checker watches every clock for these properties:
- the interrupt is one clock wide;
- the valid strobe comes exactly two clocks before the interrupt;
- `result` stays stable outside the valid clock;
- `ser_out` is low when the interrupt is sampled;
- all outputs are quiet while powered down.

Some behaviour only the directed scenarios can show:
- the exact position of each serial bit within the frame;
- the most-significant-first assembly of the byte;
- the byte surviving a power-down that lands mid-window or on the interrupt clock;
- the restart at clock 1 after release.

// File: rtl/sadc_frame_seq.sv
module sadc_frame_seq #(
  parameter int DATA_W     = 8,
  parameter int FRAME_LEN  = 16,
  parameter int CONV_EDGES = 6
) (
  input  logic              clk,
  input  logic              pwr_down,
  input  logic              ser_in,
  output logic              ser_out,
  output logic [DATA_W-1:0] result,
  output logic              result_valid,
  output logic              frame_irq
);
  localparam int CW       = $clog2(FRAME_LEN);
  localparam int FIRST_I  = CONV_EDGES - 1;
  localparam int LASTB_I  = FIRST_I + DATA_W - 1;
  localparam logic [CW-1:0] FIRST_C = CW'(FIRST_I);
  localparam logic [CW-1:0] LASTB_C = CW'(LASTB_I);
  localparam logic [CW-1:0] VALID_C = CW'(LASTB_I + 1);
  localparam logic [CW-1:0] END_C   = CW'(FRAME_LEN - 1);

  logic [CW-1:0]     cnt;
  logic [DATA_W-2:0] shreg;
  logic              in_window;

  assign in_window    = (cnt >= FIRST_C) && (cnt <= LASTB_C);
  assign result_valid = (cnt == VALID_C);
  assign frame_irq    = (cnt == END_C);

  always_ff @(posedge clk or posedge pwr_down)
    if (pwr_down)           cnt <= '0;
    else if (cnt == END_C)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;

  always_ff @(negedge clk or posedge pwr_down)
    if (pwr_down) ser_out <= 1'b0;
    else          ser_out <= in_window ? ser_in : 1'b0;

  always_ff @(posedge clk or posedge pwr_down)
    if (pwr_down)
      shreg <= '0;
    else if ((cnt >= FIRST_C) && (cnt < LASTB_C))
      shreg <= {shreg[DATA_W-3:0], ser_out};

  always_ff @(posedge clk)
    if (!pwr_down && cnt == LASTB_C)
      result <= {shreg, ser_out};
endmodule

module sadc_frame_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              pwr_down,
  input logic              ser_out,
  input logic [DATA_W-1:0] result,
  input logic              result_valid,
  input logic              frame_irq
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk)
    pwr_down |-> (!frame_irq && !result_valid && !ser_out));
  // R8
  irq_width_chk: assert property (@(posedge clk) disable iff (pwr_down)
    frame_irq |=> !frame_irq);
  // R7
  valid_to_irq_chk: assert property (@(posedge clk) disable iff (pwr_down)
    result_valid |=> ##1 frame_irq);
  // R7
  valid_width_chk: assert property (@(posedge clk) disable iff (pwr_down)
    result_valid |=> !result_valid);
  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (pwr_down)
    !result_valid |-> $stable(result));
  // R4
  ser_quiet_chk: assert property (@(posedge clk) disable iff (pwr_down)
    frame_irq |-> !ser_out);
endmodule

bind sadc_frame_seq sadc_frame_seq_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .pwr_down(pwr_down), .ser_out(ser_out), .result(result),
  .result_valid(result_valid), .frame_irq(frame_irq)
);

// File: tb/sadc_frame_seq_tb_top.sv
module sadc_frame_seq_tb_top;
  logic       clk = 1'b0;
  logic       pwr_down = 1'b1;
  logic       ser_in = 1'b0;
  logic       ser_out, result_valid, frame_irq;
  logic [7:0] result;

  int   n_tests = 0;
  int   n_fail  = 0;
  logic [7:0] last_res = '0;
  bit   have_res = 0;

  always #5 clk = ~clk;

  sadc_frame_seq dut_i (
    .clk(clk), .pwr_down(pwr_down), .ser_in(ser_in), .ser_out(ser_out),
    .result(result), .result_valid(result_valid), .frame_irq(frame_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Entry and exit: 1 ns after a rising edge, at clock index c0 of the frame.
  task automatic run_cycles(input logic [7:0] v, input int c0, input int n);
    for (int i = 0; i < n; i++) begin
      int c = c0 + i;
      bit win = (c >= 5) && (c <= 12);
      ser_in = win ? v[12-c] : 1'b1;
      @(negedge clk); #2;
      chk(ser_out == (win ? v[12-c] : 1'b0), win ? "R4 serial bit" : "R3 conversion quiet",
          ser_out, win ? v[12-c] : 0);
      chk(result_valid == (c == 13), "R7 valid strobe", result_valid, c == 13);
      chk(frame_irq == (c == 15), "R8 interrupt", frame_irq, c == 15);
      if (c >= 13) begin
        chk(result == v, "R5 parallel result", result, v);
        last_res = v; have_res = 1;
      end else if (have_res)
        chk(result == last_res, "R6 result held", result, last_res);
      @(posedge clk); #1;
    end
  endtask

  task automatic hold_down(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #2;
      chk(!frame_irq && !result_valid && !ser_out, "R1 idle outputs",
          {frame_irq, result_valid, ser_out}, 0);
      chk(result == last_res, "R6 result kept in power-down", result, last_res);
    end
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    #1;
    chk(!frame_irq && !result_valid && !ser_out, "R1 reset state",
        {frame_irq, result_valid, ser_out}, 0);
    ser_in = 1'b1;
    repeat (4) begin
      @(negedge clk); #2;
      chk(!ser_out && !frame_irq, "R1 no frame while down", {ser_out, frame_irq}, 0);
    end
    @(posedge clk); #1;
  endtask

  task automatic t_back_to_back;
    pwr_down = 1'b0;
    run_cycles(8'hA5, 0, 16);
    run_cycles(8'h00, 0, 16);   // R2 next frame with no gap
    run_cycles(8'hFF, 0, 16);
    run_cycles(8'h3C, 0, 16);
  endtask

  task automatic t_pd_mid_window;
    run_cycles(8'hFF, 0, 9);
    #2;
    chk(ser_out == 1'b1, "R4 bit before power-down", ser_out, 1);
    pwr_down = 1'b1; #1;
    chk(!ser_out, "R9 async clear ser_out", ser_out, 0);
    chk(result == last_res, "R9 partial byte dropped", result, last_res);
    hold_down(6);
    pwr_down = 1'b0;
    run_cycles(8'h5A, 0, 16);   // R9 restart at clock 1
  endtask

  task automatic t_pd_on_irq;
    run_cycles(8'hC3, 0, 15);
    chk(frame_irq == 1'b1, "R8 interrupt before power-down", frame_irq, 1);
    #2; pwr_down = 1'b1; #1;
    chk(!frame_irq && !result_valid, "R9 async clear interrupt",
        {frame_irq, result_valid}, 0);
    hold_down(5);
    pwr_down = 1'b0;
    run_cycles(8'h81, 0, 16);
    run_cycles(8'h7E, 0, 16);
  endtask

  initial begin
    t_reset();
    t_back_to_back();
    t_pd_mid_window();
    t_pd_on_irq();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule